// File: doc/BRIEF.md
# Rename Valid-Vector History Checkpoint Buffer

This block is a circular history of rename state, one entry for each decode cycle. Every push stores two valid-bit vectors over all renamable registers. The "commit" vector is the valid state the rename table holds once that decode cycle has gone through. The "backout" vector is the state it would hold if that decode cycle were cancelled. The write slot is handed back as a checkpoint tag, and any branch decoded in that cycle carries the tag with it.

When a branch turns out to be mispredicted, the tag is presented on the mispredict port. In that same cycle the block drives the rename valid vector from which decode restarts. It can hand back the state after the branch's own decode cycle, or, in drop mode, the state from before that cycle. On the next edge every younger entry is discarded. A retire port takes a count and frees that many of the oldest entries in one cycle. The commit vector of the youngest freed entry becomes the new committed rename state. A retire and a mispredict may arrive in the same cycle. The retire is then cut so that it never frees an entry the mispredict discards.

Reads go through a one-hot select per entry, merged by an OR gate per register. Because of this, the restore path and the commit path add no register stage.

Top module: `rename_hist_buf`

## Requirements
- R1: After reset the buffer is empty: `level_o` is 0, `stall_o` is 0, `push_idx_o` is 0 and `commit_o` equals the parameter `RESET_VEC`.
- R2: An accepted push stores `push_bak_i`/`push_ok_i` at slot `push_idx_o` (the checkpoint tag, shown in the same cycle), after which `push_idx_o` advances by one and `level_o` grows by one less the entries retired in that cycle.
- R3: `stall_o` is 1 exactly when `level_o` equals `DEPTH`. A push while `stall_o` is 1 is ignored.
- R4: A mispredict (`mis_i`=1, `mis_drop_i`=0) with an in-range tag k sets `restore_vld_o`=1 and drives `restore_o` with the commit vector of slot k in the same cycle. From the next cycle the slot after k is the youngest kept and becomes the next tag.
- R5: With `mis_drop_i`=1 the mispredict drives the backout vector of slot k and also discards slot k itself, so k becomes the next tag.
- R6: A push in the same cycle as an accepted mispredict is ignored.
- R7: A retire count n frees min(n, `level_o`) oldest entries on the next edge. If at least one is freed, `commit_o` becomes the commit vector of the youngest freed entry. Otherwise `commit_o` holds.
- R8: With a same-cycle accepted mispredict, the retire is further limited to the entries up to and including k (keep mode) or older than k (drop mode).
- R9: A tag that does not name an occupied slot (its distance from the oldest slot, modulo `DEPTH`, is not below `level_o`) raises `mis_err_o` in the same cycle, keeps `restore_vld_o` at 0 and changes no pointer.
- R10: Tags and pointers wrap modulo `DEPTH`, so the buffer works across any number of wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Record one decode cycle |
| push_bak_i | input | NREG | Valid vector if that decode cycle is backed out |
| push_ok_i | input | NREG | Valid vector if that decode cycle goes through |
| push_idx_o | output | log2(DEPTH) | Checkpoint tag of the slot a push would fill |
| stall_o | output | 1 | Buffer full; decode must hold |
| mis_i | input | 1 | Branch mispredict strobe |
| mis_idx_i | input | log2(DEPTH) | Checkpoint tag of the mispredicted branch |
| mis_drop_i | input | 1 | 1: also cancel the branch's own decode cycle |
| ret_cnt_i | input | log2(DEPTH)+1 | Number of oldest entries to retire |
| restore_o | output | NREG | Restored rename valid vector |
| restore_vld_o | output | 1 | `restore_o` is meaningful this cycle |
| mis_err_o | output | 1 | Mispredict tag out of range |
| commit_o | output | NREG | Committed rename valid state |
| level_o | output | log2(DEPTH)+1 | Occupied entries |

## Verification
The in-RTL properties check several things on every cycle. Occupancy never exceeds the depth, and the retire count actually applied never exceeds occupancy. Under a mispredict the applied retire stays within the kept window, and occupancy afterwards fits that window. An out-of-range tag leaves both pointers still, and the committed vector cannot move on a cycle that frees nothing. Only the bench's scenarios can show that the data is right. That covers which stored vector comes back on `restore_o` in each mode, which entry's vector lands on `commit_o`, that the tags handed out after a backup reuse the discarded slots, and that these relations hold across many wrap-arounds.

// File: rtl/rhb_pkg.sv
package rhb_pkg;

   // How a mispredict treats the branch's own decode cycle.
   typedef enum logic {
      RHB_KEEP_SELF = 1'b0,
      RHB_DROP_SELF = 1'b1
   } rhb_mode_e;

endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
   parameter int NREG  = 8,
   parameter int DEPTH = 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [IW-1:0]   waddr,
   input  logic [NREG-1:0] wbak,
   input  logic [NREG-1:0] wok,
   input  logic [IW-1:0]   rst_idx,
   input  logic            rst_drop,
   output logic [NREG-1:0] rst_vec,
   input  logic [IW-1:0]   cmt_idx,
   output logic [NREG-1:0] cmt_vec
);
   logic [NREG-1:0] bak_q [DEPTH];
   logic [NREG-1:0] ok_q  [DEPTH];
   logic [NREG-1:0] pick_r [DEPTH];
   logic [NREG-1:0] pick_c [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         bak_q[waddr] <= wbak;
         ok_q[waddr]  <= wok;
      end
   end

   // One-hot select per entry; the read is an OR over selected entries.
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic sel_r, sel_c;
      assign sel_r     = (rst_idx == IW'(e));
      assign sel_c     = (cmt_idx == IW'(e));
      assign pick_r[e] = {NREG{sel_r}} & (rst_drop ? bak_q[e] : ok_q[e]);
      assign pick_c[e] = {NREG{sel_c}} & ok_q[e];
   end

   always_comb begin
      rst_vec = '0;
      cmt_vec = '0;
      for (int e = 0; e < DEPTH; e++) begin
         rst_vec = rst_vec | pick_r[e];
         cmt_vec = cmt_vec | pick_c[e];
      end
   end
endmodule

// File: rtl/rhb_ptr.sv
module rhb_ptr #(
   parameter int DEPTH = 8,
   localparam int IW   = $clog2(DEPTH),
   localparam int PW   = IW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          mis,
   input  logic [IW-1:0] mis_idx,
   input  logic          mis_drop,
   input  logic [PW-1:0] ret_cnt,
   output logic [IW-1:0] tail_idx,
   output logic [IW-1:0] cmt_idx,
   output logic [PW-1:0] level,
   output logic [PW-1:0] ret_eff,
   output logic          full,
   output logic          mis_ok,
   output logic          mis_err,
   output logic          push_acc
);
   logic [PW-1:0] head_q, tail_q;
   logic [IW-1:0] off;
   logic [PW-1:0] off_x, keep_cnt, ret_cap;
   logic          in_range;

   assign level    = tail_q - head_q;
   assign full     = (level == PW'(DEPTH));
   assign tail_idx = tail_q[IW-1:0];

   assign off      = mis_idx - head_q[IW-1:0];
   assign off_x    = {1'b0, off};
   assign in_range = (off_x < level);
   assign mis_ok   = mis & in_range;
   assign mis_err  = mis & ~in_range;

   // Entries that survive a backup: up to k, with or without k itself.
   assign keep_cnt = off_x + (mis_drop ? PW'(0) : PW'(1));
   assign ret_cap  = (ret_cnt < level) ? ret_cnt : level;
   assign ret_eff  = (mis_ok && keep_cnt < ret_cap) ? keep_cnt : ret_cap;
   assign push_acc = push & ~full & ~mis_ok;
   assign cmt_idx  = head_q[IW-1:0] + ret_eff[IW-1:0] - IW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_q + ret_eff;
         if (mis_ok)        tail_q <= head_q + keep_cnt;
         else if (push_acc) tail_q <= tail_q + PW'(1);
      end
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= PW'(DEPTH));
   // R7
   retire_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_eff <= level);
   // R8
   retire_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mis_ok |-> ret_eff <= off_x + PW'(1));
   // R4
   backup_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mis_ok |=> level <= $past(off_x) + PW'(1));
   // R9
   bad_tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mis_err && !push && ret_cnt == '0) |=> ($stable(head_q) && $stable(tail_q)));
   // R2
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_acc && ret_eff == '0) |=> level == $past(level) + PW'(1));
endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf #(
   parameter int              NREG      = 8,
   parameter int              DEPTH     = 8,
   parameter logic [NREG-1:0] RESET_VEC = '1,
   localparam int             IW        = $clog2(DEPTH),
   localparam int             PW        = IW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push_i,
   input  logic [NREG-1:0] push_bak_i,
   input  logic [NREG-1:0] push_ok_i,
   output logic [IW-1:0]   push_idx_o,
   output logic            stall_o,
   input  logic            mis_i,
   input  logic [IW-1:0]   mis_idx_i,
   input  logic            mis_drop_i,
   input  logic [PW-1:0]   ret_cnt_i,
   output logic [NREG-1:0] restore_o,
   output logic            restore_vld_o,
   output logic            mis_err_o,
   output logic [NREG-1:0] commit_o,
   output logic [PW-1:0]   level_o
);
   import rhb_pkg::*;

   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("rename_hist_buf: DEPTH must be a power of two >= 2");
   end
   if (NREG < 1) begin : g_bad_nreg
      $error("rename_hist_buf: NREG must be at least 1");
   end

   rhb_mode_e       mode;
   logic [IW-1:0]   tail_idx, cmt_idx;
   logic [PW-1:0]   ret_eff;
   logic            full, mis_ok, mis_err, push_acc;
   logic [NREG-1:0] rst_vec, cmt_vec, commit_q;

   assign mode = rhb_mode_e'(mis_drop_i);

   rhb_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push_i),
      .mis      (mis_i),
      .mis_idx  (mis_idx_i),
      .mis_drop (mode == RHB_DROP_SELF),
      .ret_cnt  (ret_cnt_i),
      .tail_idx (tail_idx),
      .cmt_idx  (cmt_idx),
      .level    (level_o),
      .ret_eff  (ret_eff),
      .full     (full),
      .mis_ok   (mis_ok),
      .mis_err  (mis_err),
      .push_acc (push_acc)
   );

   rhb_store #(.NREG(NREG), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .we       (push_acc),
      .waddr    (tail_idx),
      .wbak     (push_bak_i),
      .wok      (push_ok_i),
      .rst_idx  (mis_idx_i),
      .rst_drop (mode == RHB_DROP_SELF),
      .rst_vec  (rst_vec),
      .cmt_idx  (cmt_idx),
      .cmt_vec  (cmt_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              commit_q <= RESET_VEC;
      else if (ret_eff != '0)  commit_q <= cmt_vec;
   end

   assign push_idx_o    = tail_idx;
   assign stall_o       = full;
   assign restore_o     = rst_vec;
   assign restore_vld_o = mis_ok;
   assign mis_err_o     = mis_err;
   assign commit_o      = commit_q;

   // R7
   commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_eff == '0) |=> $stable(commit_o));
   // R6
   push_vs_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mis_i && restore_vld_o) |-> !push_acc);
   // R9
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(restore_vld_o && mis_err_o));
endmodule

// File: tb/rename_hist_buf_tb.sv
module rename_hist_buf_tb;
   localparam int NREG = 8;
   localparam int DEPTH = 8;
   localparam logic [NREG-1:0] RVEC = 8'hA5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push_i = 1'b0;
   logic [NREG-1:0] push_bak_i = '0, push_ok_i = '0;
   logic [2:0] push_idx_o;
   logic stall_o;
   logic mis_i = 1'b0;
   logic [2:0] mis_idx_i = '0;
   logic mis_drop_i = 1'b0;
   logic [3:0] ret_cnt_i = '0;
   logic [NREG-1:0] restore_o, commit_o;
   logic restore_vld_o, mis_err_o;
   logic [3:0] level_o;

   int n_chk = 0, n_bad = 0;
   int mh = 0, mt = 0;
   logic [NREG-1:0] mok [DEPTH];
   logic [NREG-1:0] mbak [DEPTH];
   logic [NREG-1:0] mcommit = RVEC;
   int seq = 0;

   always #2 clk = ~clk;

   rename_hist_buf #(.NREG(NREG), .DEPTH(DEPTH), .RESET_VEC(RVEC)) u_dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_bak_i(push_bak_i),
      .push_ok_i(push_ok_i), .push_idx_o(push_idx_o), .stall_o(stall_o),
      .mis_i(mis_i), .mis_idx_i(mis_idx_i), .mis_drop_i(mis_drop_i),
      .ret_cnt_i(ret_cnt_i), .restore_o(restore_o),
      .restore_vld_o(restore_vld_o), .mis_err_o(mis_err_o),
      .commit_o(commit_o), .level_o(level_o));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // One cycle of stimulus, checked against the snapshot model.
   task automatic step(input logic p, input logic m, input logic [2:0] k,
                       input logic d, input int r);
      int lvl, off, reff, lim;
      logic inr;
      logic [NREG-1:0] o, b;
      @(negedge clk);
      seq++;
      o = NREG'(seq * 37 + 11);
      b = ~NREG'(seq * 53 + 5);
      push_i = p; push_ok_i = o; push_bak_i = b;
      mis_i = m; mis_idx_i = k; mis_drop_i = d; ret_cnt_i = 4'(r);
      #1;
      lvl = mt - mh;
      off = (int'(k) - (mh % DEPTH) + DEPTH) % DEPTH;
      inr = off < lvl;
      chk("R3 stall", int'(stall_o), int'(lvl == DEPTH));
      chk("R2 tag", int'(push_idx_o), mt % DEPTH);
      chk("R9 err", int'(mis_err_o), int'(m && !inr));
      chk("R4 vld", int'(restore_vld_o), int'(m && inr));
      if (m && inr) begin
         if (d) chk("R5 restore", int'(restore_o), int'(mbak[k]));
         else   chk("R4 restore", int'(restore_o), int'(mok[k]));
      end
      reff = (r < lvl) ? r : lvl;
      if (m && inr) begin
         lim = off + (d ? 0 : 1);
         if (lim < reff) reff = lim;
      end
      if (reff > 0) mcommit = mok[(mh + reff - 1) % DEPTH];
      if (m && inr) mt = mh + off + (d ? 0 : 1);
      else if (p && lvl < DEPTH) begin
         mbak[mt % DEPTH] = b;
         mok[mt % DEPTH] = o;
         mt++;
      end
      mh += reff;
      @(posedge clk);
      #1;
      chk("R7 commit", int'(commit_o), int'(mcommit));
      chk("R2 level", int'(level_o), mt - mh);
      push_i = 1'b0; mis_i = 1'b0; ret_cnt_i = '0;
   endtask

   function automatic logic [2:0] tag_at(input int rel);
      return 3'((mh + rel) % DEPTH);
   endfunction

   task automatic t_reset();
      #1;
      chk("R1 level", int'(level_o), 0);
      chk("R1 stall", int'(stall_o), 0);
      chk("R1 tag", int'(push_idx_o), 0);
      chk("R1 commit", int'(commit_o), int'(RVEC));
   endtask

   task automatic t_fill_stall();
      for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, 0);
      chk("R3 full", int'(stall_o), 1);
      step(1, 0, 0, 0, 0);
      chk("R3 ignored push", int'(level_o), DEPTH);
   endtask

   task automatic t_retire();
      logic [NREG-1:0] last;
      last = mok[(mt - 1) % DEPTH];
      step(0, 0, 0, 0, DEPTH);
      chk("R7 all retired", int'(commit_o), int'(last));
      chk("R7 empty", int'(level_o), 0);
      step(0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      last = mok[(mt - 1) % DEPTH];
      step(0, 0, 0, 0, 5);
      chk("R7 clamp", int'(commit_o), int'(last));
   endtask

   task automatic t_backup_keep();
      logic [2:0] k;
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0);
      k = tag_at(2);
      step(0, 1, k, 0, 0);
      chk("R4 next tag", int'(push_idx_o), int'(3'(k + 3'd1)));
      chk("R4 level", int'(level_o), 3);
   endtask

   task automatic t_backup_drop();
      logic [2:0] k;
      step(1, 0, 0, 0, 0);
      k = tag_at(1);
      step(0, 1, k, 1, 0);
      chk("R5 next tag", int'(push_idx_o), int'(k));
      chk("R5 level", int'(level_o), 1);
   endtask

   task automatic t_push_with_backup();
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      step(1, 1, tag_at(0), 0, 0);
      chk("R6 push ignored", int'(level_o), 1);
   endtask

   task automatic t_combined();
      logic [2:0] k;
      step(0, 0, 0, 0, DEPTH);
      for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0);
      k = tag_at(3);
      step(0, 1, k, 0, 6);
      chk("R8 keep limit", int'(level_o), 0);
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0);
      k = tag_at(2);
      step(0, 1, k, 1, 5);
      chk("R8 drop limit", int'(level_o), 0);
      chk("R8 next tag", int'(push_idx_o), int'(k));
   endtask

   task automatic t_bad_tag();
      int lv;
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
      lv = mt - mh;
      step(0, 1, tag_at(5), 0, 0);
      chk("R9 no change", int'(level_o), lv);
   endtask

   task automatic t_wrap_mix();
      for (int i = 0; i < 400; i++) begin
         int lvl, rel;
         logic p, m;
         lvl = mt - mh;
         p = ($urandom % 4) != 0;
         m = ($urandom % 9) == 0;
         rel = (lvl > 0 && ($urandom % 5) != 0) ? int'($urandom % lvl) : int'($urandom % DEPTH);
         step(p, m, tag_at(rel), 1'($urandom % 2), int'($urandom % 3));
      end
      chk("R10 wrapped", int'(mt > 3 * DEPTH), 1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill_stall();
      t_retire();
      t_backup_keep();
      t_backup_drop();
      t_push_with_backup();
      t_combined();
      t_bad_tag();
      t_wrap_mix();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule